// File: doc/BRIEF.md
# Serial UART peripheral with two-stage baud divider

The block is a register-mapped asynchronous serial port that sends and receives 8N1 characters: one low start bit, eight data bits with the least significant bit first, and one high stop bit. The bus side uses simple single-cycle 32-bit accesses. Software sets the bit rate in a baud register, enables each direction in a control register, watches a status register, and moves bytes through a data register.

The bit clock comes from the system clock in two stages. A sub-rate divider (SBR) produces an oversampling tick. The oversampling factor, stored as factor minus one (OSR), then counts those ticks into one bit period. The transmitter has a one-entry holding register in front of its shift register. It therefore reports two separate things: when the holding register can take another byte, and when the line has fully drained. The receiver runs on the same oversampling tick. It confirms the start bit near its middle, samples each bit near its centre, and reports a full byte, an overrun or a bad stop bit.

Top module: `uart_periph`

## Requirements
- R1: The TX line (`tx_o`) is high after reset and while idle. Each transmitted frame is a 0 start bit, then the data byte with bit 0 first, then a 1 stop bit.
- R2: One bit lasts (OSR+1)×SBR clocks. The baud register at offset 0x10 holds OSR in bits 28:24 and SBR in bits 12:0. It resets to OSR=15 and SBR=4, and it reads back what was written.
- R3: With OSR=15 and SBR=26, a bit lasts 416 clocks. A byte takes about 4160 clocks from the DATA write until transmit-complete sets.
- R4: The status register is at offset 0x14. Bit 7 is transmit-data-empty. After a write to DATA (offset 0x1C) while the transmitter is enabled and idle, bit 7 reads 1 again one cycle later, while bit 6 (transmit-complete) still reads 0. After reset, status reads 0x000000C0.
- R5: Transmit-complete (status bit 6) sets between 10×P−SBR and 10×P+1 clocks after the byte moves into the shift register, where P is the bit period.
- R6: A correctly framed received byte sets receive-full (status bit 5). Reading DATA returns the byte in bits 7:0 and clears receive-full.
- R7: If a byte completes while receive-full is still set, overrun (status bit 3) sets and the new byte is discarded, so DATA keeps the older byte.
- R8: A stop bit sampled as 0 sets framing-error (status bit 1). The byte is still stored.
- R9: The control register is at offset 0x18 and resets to 0. Bit 19 enables the transmitter: while it is 0, a queued byte stays in the holding register and the line stays high. Bit 18 enables the receiver: while it is 0, incoming frames are ignored.
- R10: With SBR=0 the oversampling tick stops. A frame in progress freezes with the line held at its current level and transmit-complete stays 0. Writing a nonzero SBR lets the frame finish.
- R11: Writing 1 to status bit 3 clears overrun, and writing 1 to status bit 1 clears framing-error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read (a read of DATA pops the received byte) |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| rx_i | input | 1 | Serial receive line, idle high |
| tx_o | output | 1 | Serial transmit line, idle high |

## Verification
The assertions rely on three conditions. OSR is at least 3, so the receiver's half-bit confirmation and the centre samples have some margin. Baud settings are changed only while neither direction is in the middle of a frame, except for the deliberate SBR stall. A read of DATA is a single-cycle strobe. The stimulus programs every baud setting between frames and uses OSR values of 3 or more. It drives received frames either by looping the TX line back or with whole bit periods whose length matches the programmed setting. The one exception is the bad stop bit, which is cut to three quarters of a bit so that its low tail cannot look like a new start bit.

// File: rtl/uart_periph_pkg.sv
package uart_periph_pkg;
  // register byte offsets
  localparam int OFS_BAUD = 'h10;
  localparam int OFS_STAT = 'h14;
  localparam int OFS_CTRL = 'h18;
  localparam int OFS_DATA = 'h1C;
  // field positions
  localparam int BAUD_OSR_LSB = 24;
  localparam int ST_TDE = 7;
  localparam int ST_TC  = 6;
  localparam int ST_RXF = 5;
  localparam int ST_OVR = 3;
  localparam int ST_FE  = 1;
  localparam int CT_TE  = 19;
  localparam int CT_RE  = 18;
  localparam int FRAME_BITS = 10;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/uart_periph_baud.sv
module uart_periph_baud #(
  parameter int SBR_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SBR_W-1:0] sbr,
  output logic             os_tick
);
  logic [SBR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    os_tick = (sbr != '0) && (cnt_q >= sbr - 1'b1);
    if (sbr == '0 || os_tick) cnt_d = '0;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && sbr > 1) |=> (!$stable(sbr) || !os_tick)); // R2
endmodule

// File: rtl/uart_periph_tx.sv
module uart_periph_tx
  import uart_periph_pkg::*;
#(
  parameter int OSR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             os_tick,
  input  logic [OSR_W-1:0] osr,
  input  logic             te,
  input  logic             wr_data,
  input  logic [7:0]       wdata,
  output logic             tde,
  output logic             tc,
  output logic             tx_o
);
  logic [7:0]            hold_q, hold_d;
  logic                  full_q, full_d;
  logic                  busy_q, busy_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [OSR_W-1:0]      ocnt_q, ocnt_d;
  logic [3:0]            left_q, left_d;
  logic                  load;

  always_comb begin
    hold_d = hold_q; full_d = full_q; busy_d = busy_q;
    sh_d = sh_q; ocnt_d = ocnt_q; left_d = left_q;
    load = te && full_q && !busy_q;
    if (wr_data) begin
      hold_d = wdata;
      full_d = 1'b1;
    end else if (load) begin
      full_d = 1'b0;
    end
    if (load) begin
      busy_d = 1'b1;
      sh_d   = {1'b1, hold_q, 1'b0};
      ocnt_d = '0;
      left_d = 4'(FRAME_BITS);
    end else if (busy_q && os_tick) begin
      if (ocnt_q >= osr) begin
        ocnt_d = '0;
        sh_d   = {1'b1, sh_q[FRAME_BITS-1:1]};
        left_d = left_q - 1'b1;
        if (left_q == 4'd1) busy_d = 1'b0;
      end else begin
        ocnt_d = ocnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0; full_q <= 1'b0; busy_q <= 1'b0;
      sh_q <= '1; ocnt_q <= '0; left_q <= '0;
    end else begin
      hold_q <= hold_d; full_q <= full_d; busy_q <= busy_d;
      sh_q <= sh_d; ocnt_q <= ocnt_d; left_q <= left_d;
    end
  end

  assign tx_o = busy_q ? sh_q[0] : 1'b1;
  assign tde  = !full_q;
  assign tc   = !full_q && !busy_q;

  AST_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr_data) |=> (busy_q && !full_q)); // R4
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !os_tick) |=> $stable(tx_o)); // R1
endmodule

// File: rtl/uart_periph_rx.sv
module uart_periph_rx
  import uart_periph_pkg::*;
#(
  parameter int OSR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             os_tick,
  input  logic [OSR_W-1:0] osr,
  input  logic             re,
  input  logic             rx_i,
  output logic             done,
  output logic [7:0]       data,
  output logic             stop_ok
);
  rx_state_t        st_q, st_d;
  logic [1:0]       sync_q;
  logic [OSR_W-1:0] cnt_q, cnt_d, half_m1;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic             done_q, done_d, stop_q, stop_d;
  logic             rxs;

  assign rxs     = sync_q[1];
  assign half_m1 = (osr >> 1) - 1'b1;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; bit_d = bit_q; sh_d = sh_q;
    done_d = 1'b0; stop_d = stop_q;
    if (!re) begin
      st_d  = RX_IDLE;
      cnt_d = '0;
    end else if (os_tick) begin
      unique case (st_q)
        RX_IDLE: if (!rxs) begin st_d = RX_START; cnt_d = '0; end
        RX_START:
          if (cnt_q >= half_m1) begin
            cnt_d = '0; bit_d = '0;
            st_d  = rxs ? RX_IDLE : RX_DATA;
          end else cnt_d = cnt_q + 1'b1;
        RX_DATA:
          if (cnt_q >= osr) begin
            cnt_d = '0;
            sh_d  = {rxs, sh_q[7:1]};
            bit_d = bit_q + 1'b1;
            if (bit_q == 3'd7) st_d = RX_STOP;
          end else cnt_d = cnt_q + 1'b1;
        RX_STOP:
          if (cnt_q >= osr) begin
            cnt_d = '0; done_d = 1'b1; stop_d = rxs; st_d = RX_IDLE;
          end else cnt_d = cnt_q + 1'b1;
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RX_IDLE; sync_q <= 2'b11; cnt_q <= '0; bit_q <= '0;
      sh_q <= '0; done_q <= 1'b0; stop_q <= 1'b1;
    end else begin
      st_q <= st_d; sync_q <= {sync_q[0], rx_i}; cnt_q <= cnt_d;
      bit_q <= bit_d; sh_q <= sh_d; done_q <= done_d; stop_q <= stop_d;
    end
  end

  assign done    = done_q;
  assign data    = sh_q;
  assign stop_ok = stop_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R6
endmodule

// File: rtl/uart_periph.sv
module uart_periph
  import uart_periph_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int OSR_W   = 5,
  parameter int SBR_W   = 13,
  parameter int OSR_RST = 15,
  parameter int SBR_RST = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_i,
  output logic        tx_o
);
  logic [1:0]       rsync_q;
  logic             rst_int_n;
  logic [OSR_W-1:0] osr_q, osr_d;
  logic [SBR_W-1:0] sbr_q, sbr_d;
  logic             te_q, te_d, re_q, re_d;
  logic [7:0]       rxd_q, rxd_d;
  logic             rxf_q, rxf_d, ovr_q, ovr_d, fe_q, fe_d;
  logic             wr, rd_data, wr_data, os_tick;
  logic             tde, tc, rx_done, rx_stop;
  logic [7:0]       rx_byte;
  logic             unused_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  assign wr      = bus_sel && bus_wr;
  assign wr_data = wr && (bus_addr == ADDR_W'(OFS_DATA));
  assign rd_data = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_DATA));
  assign unused_bits = ^{bus_wdata[31:29], bus_wdata[23:20], bus_wdata[17:13]};

  uart_periph_baud #(.SBR_W(SBR_W)) u_baud (
    .clk(clk), .rst_n(rst_int_n), .sbr(sbr_q), .os_tick(os_tick));

  uart_periph_tx #(.OSR_W(OSR_W)) u_tx (
    .clk(clk), .rst_n(rst_int_n), .os_tick(os_tick), .osr(osr_q), .te(te_q),
    .wr_data(wr_data), .wdata(bus_wdata[7:0]), .tde(tde), .tc(tc), .tx_o(tx_o));

  uart_periph_rx #(.OSR_W(OSR_W)) u_rx (
    .clk(clk), .rst_n(rst_int_n), .os_tick(os_tick), .osr(osr_q), .re(re_q),
    .rx_i(rx_i), .done(rx_done), .data(rx_byte), .stop_ok(rx_stop));

  always_comb begin
    osr_d = osr_q; sbr_d = sbr_q; te_d = te_q; re_d = re_q;
    rxd_d = rxd_q; rxf_d = rxf_q; ovr_d = ovr_q; fe_d = fe_q;
    if (wr && bus_addr == ADDR_W'(OFS_BAUD)) begin
      osr_d = bus_wdata[BAUD_OSR_LSB +: OSR_W];
      sbr_d = bus_wdata[SBR_W-1:0];
    end
    if (wr && bus_addr == ADDR_W'(OFS_CTRL)) begin
      te_d = bus_wdata[CT_TE];
      re_d = bus_wdata[CT_RE];
    end
    if (wr && bus_addr == ADDR_W'(OFS_STAT)) begin
      if (bus_wdata[ST_OVR]) ovr_d = 1'b0;
      if (bus_wdata[ST_FE])  fe_d  = 1'b0;
    end
    if (rd_data) rxf_d = 1'b0;
    if (rx_done) begin
      if (rxf_q && !rd_data) begin
        ovr_d = 1'b1;
      end else begin
        rxd_d = rx_byte;
        rxf_d = 1'b1;
        if (!rx_stop) fe_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      osr_q <= OSR_W'(OSR_RST); sbr_q <= SBR_W'(SBR_RST);
      te_q <= 1'b0; re_q <= 1'b0; rxd_q <= '0;
      rxf_q <= 1'b0; ovr_q <= 1'b0; fe_q <= 1'b0;
    end else begin
      osr_q <= osr_d; sbr_q <= sbr_d; te_q <= te_d; re_q <= re_d;
      rxd_q <= rxd_d; rxf_q <= rxf_d; ovr_q <= ovr_d; fe_q <= fe_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_W'(OFS_BAUD): begin
        bus_rdata[BAUD_OSR_LSB +: OSR_W] = osr_q;
        bus_rdata[SBR_W-1:0]             = sbr_q;
      end
      ADDR_W'(OFS_STAT): begin
        bus_rdata[ST_TDE] = tde;
        bus_rdata[ST_TC]  = tc;
        bus_rdata[ST_RXF] = rxf_q;
        bus_rdata[ST_OVR] = ovr_q;
        bus_rdata[ST_FE]  = fe_q;
      end
      ADDR_W'(OFS_CTRL): begin
        bus_rdata[CT_TE] = te_q;
        bus_rdata[CT_RE] = re_q;
      end
      ADDR_W'(OFS_DATA): bus_rdata[7:0] = rxd_q;
      default: bus_rdata = '0;
    endcase
  end

  AST_RXF_CLEAR: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_data && !rx_done) |=> !rxf_q); // R6
  AST_OVERRUN: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rx_done && rxf_q && !rd_data) |=> (ovr_q && $stable(rxd_q))); // R7
endmodule

// File: tb/uart_periph_bench.sv
module uart_periph_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_BAUD = 5'h10, A_STAT = 5'h14, A_CTRL = 5'h18, A_DATA = 5'h1C;
  localparam int NVEC = 6;
  // {osr, sbr, byte}
  localparam logic [25:0] VEC [NVEC] = '{
    {5'd3,  13'd2,  8'h59}, {5'd3,  13'd3, 8'hA5}, {5'd7, 13'd1, 8'h00},
    {5'd5,  13'd2,  8'hFF}, {5'd15, 13'd1, 8'h80}, {5'd15, 13'd26, 8'h41}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic loop_en = 1'b0, rx_drv = 1'b1, rx_i, tx_o;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rx_i = loop_en ? tx_o : rx_drv;

  uart_periph u_uart_periph (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_i(rx_i), .tx_o(tx_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic set_baud(input int osr, input int sbr);
    wr(A_BAUD, (osr << 24) | sbr);
  endtask

  // poll until transmit-complete, counting cycles from start value e
  task automatic wait_tc(inout int e, input int limit);
    logic [31:0] s;
    for (int k = 0; k < limit; k++) begin
      rd(A_STAT, s);
      if (s[6]) return;
      e++;
    end
  endtask

  task automatic send_and_check(input int osr, input int sbr, input logic [7:0] b);
    logic [31:0] s;
    logic [9:0] cap;
    int p, e;
    p = (osr + 1) * sbr;
    wr(A_DATA, {24'h0, b});
    @(negedge clk);
    rd(A_STAT, s);
    chk("R4 handoff tde=1 tc=0", {30'h0, s[7:6]}, 32'h2);
    repeat (p/2 - 1) @(negedge clk);
    cap[0] = tx_o;
    for (int i = 1; i < 10; i++) begin
      repeat (p) @(negedge clk);
      cap[i] = tx_o;
    end
    chk("R1 start bit", {31'h0, cap[0]}, 32'h0);
    chk("R1 data lsb first", {24'h0, cap[8:1]}, {24'h0, b});
    chk("R1 stop bit", {31'h0, cap[9]}, 32'h1);
    e = p/2 + 9*p;
    wait_tc(e, 20*p);
    chk_rng("R5 tc timing", e, 10*p - sbr, 10*p + 1);
    if (osr == 15 && sbr == 26) chk_rng("R3 byte time at 416 clk/bit", e, 4140, 4170);
  endtask

  task automatic drv_frame(input logic [7:0] b, input logic stop, input int p);
    rx_drv = 1'b0; repeat (p) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rx_drv = b[i]; repeat (p) @(negedge clk); end
    rx_drv = stop;
    repeat (stop ? p : (3*p)/4) @(negedge clk);
    rx_drv = 1'b1; repeat (2*p) @(negedge clk);
  endtask

  initial begin
    logic [31:0] s;
    int osr, sbr, e;
    bit held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R1 tx idle high after reset", {31'h0, tx_o}, 32'h1);
    rd(A_STAT, s); chk("R4 reset status", s, 32'h000000C0);
    rd(A_BAUD, s); chk("R2 reset baud", s, (32'd15 << 24) | 32'd4);
    rd(A_CTRL, s); chk("R9 reset ctrl", s, 32'h0);

    wr(A_CTRL, (32'd1 << 19) | (32'd1 << 18));
    loop_en = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      osr = int'(VEC[v][25:21]);
      sbr = int'(VEC[v][20:8]);
      set_baud(osr, sbr);
      rd(A_BAUD, s); chk("R2 baud readback", s, (osr << 24) | sbr);
      send_and_check(osr, sbr, VEC[v][7:0]);
      repeat ((osr + 1) * sbr) @(negedge clk);
      rd(A_STAT, s); chk("R6 rx full set", {31'h0, s[5]}, 32'h1);
      rd(A_DATA, s); chk("R6 rx byte", s, {24'h0, VEC[v][7:0]});
      rd(A_STAT, s); chk("R6 rx full cleared by read", {31'h0, s[5]}, 32'h0);
    end

    // overrun
    set_baud(3, 2);
    send_and_check(3, 2, 8'h12);
    repeat (8) @(negedge clk);
    send_and_check(3, 2, 8'h34);
    repeat (8) @(negedge clk);
    rd(A_STAT, s); chk("R7 overrun and full", {30'h0, s[5], s[3]}, 32'h3);
    rd(A_DATA, s); chk("R7 older byte kept", s, 32'h12);
    wr(A_STAT, 32'h8);
    rd(A_STAT, s); chk("R11 overrun cleared", {31'h0, s[3]}, 32'h0);

    // framing error
    loop_en = 1'b0;
    drv_frame(8'h5A, 1'b0, 8);
    rd(A_STAT, s); chk("R8 framing error", {30'h0, s[5], s[1]}, 32'h3);
    rd(A_DATA, s); chk("R8 byte stored", s, 32'h5A);
    wr(A_STAT, 32'h2);
    rd(A_STAT, s); chk("R11 framing cleared", {31'h0, s[1]}, 32'h0);

    // receiver disabled
    wr(A_CTRL, 32'd1 << 19);
    drv_frame(8'hC3, 1'b1, 8);
    rd(A_STAT, s); chk("R9 rx disabled ignores frame", {31'h0, s[5]}, 32'h0);

    // transmitter disabled
    wr(A_CTRL, 32'h0);
    wr(A_DATA, 32'h77);
    held = 1'b1;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (tx_o !== 1'b1) held = 1'b0; end
    chk("R9 tx disabled line high", {31'h0, held}, 32'h1);
    rd(A_STAT, s); chk("R9 byte held tde=0 tc=0", {30'h0, s[7:6]}, 32'h0);
    wr(A_CTRL, 32'd1 << 19);
    e = 0;
    wait_tc(e, 200);
    chk_rng("R9 held byte sent after enable", e, 70, 84);

    // SBR zero stall
    set_baud(3, 0);
    wr(A_DATA, 32'h0F);
    repeat (3) @(negedge clk);
    held = 1'b1;
    for (int k = 0; k < 100; k++) begin @(negedge clk); if (tx_o !== 1'b0) held = 1'b0; end
    chk("R10 line frozen at start bit", {31'h0, held}, 32'h1);
    rd(A_STAT, s); chk("R10 tc stays 0", {31'h0, s[6]}, 32'h0);
    set_baud(3, 2);
    e = 0;
    wait_tc(e, 200);
    chk_rng("R10 frame resumes", e, 76, 84);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule